// File: doc/BRIEF.md
# Simultaneous-Sampling Conversion Group Sequencer

This block is the digital control core of a multichannel sampling converter. It waits for a start request that may arrive asynchronously to the system clock. It then latches a two-bit group mode and a two-bit auxiliary selection and runs one conversion group. A group is a series of fixed-length conversion slots, one for each channel the mode selects. Between groups there is a fixed-length hold/acquisition phase. The block drives a BUSY output and collects one 11-bit result per slot from an external converter stub into a shadow bank. It copies the shadow values into the readable result registers only when the group completes.

All sequencing state changes on the falling edge of the system clock. The converter stub sees the slot being converted on `conv_slot_o` and the latched auxiliary selection on `conv_aux_o`. It must hold `conv_data_i` valid by the last cycle of each slot, and the block samples it there.

The result path has no valid/ready handshake and no back-pressure. The slot length is fixed, so a result arrives once per slot whether or not anything reads it. The readable registers simply hold the last completed group until the next group completes.

Top module: `adc_group_sequencer`

## Requirements
- R1: While `rst_n` is low, `busy_o` is 1 and all four result registers read 0. For 20 falling clock edges after reset is released, the block is in its acquisition phase, and a start request arriving then is ignored.
- R2: A rising edge on `start_i` passes through two synchroniser flops and is qualified on a falling clock edge. If `start_i` rises just after a rising clock edge, `busy_o` is still 1 two rising edges later and is 0 three rising edges later.
- R3: The mode is latched at the qualifying edge and picks the group. Mode 00 gives VIN2, VIN3. Mode 01 gives VIN2, VIN3, AUX. Mode 10 gives VIN1, VIN2, VIN3. Mode 11 gives all four. Only the selected channels are converted and written.
- R4: Slots run in the fixed order VIN1, VIN2, VIN3, AUX, and unselected channels are skipped. `conv_slot_o` codes the slot as 0 for VIN1, 1 for VIN2, 2 for VIN3 and 3 for AUX.
- R5: The auxiliary select is latched at the qualifying edge and is driven on `conv_aux_o` for the whole group. Values 00, 01, 10 and 11 route AUX0, AUX1, AUX2 and AUX3. The AUX result register holds the result converted under that selection.
- R6: Changes on `mode_i` or `aux_sel_i` after the qualifying edge have no effect on the group in progress.
- R7: `busy_o` stays 0 for exactly 40 clock cycles per converted channel (80, 120 or 160).
- R8: The result registers keep the previous group's values for as long as `busy_o` is 0. The new values appear on the same edge on which `busy_o` returns to 1. A register whose channel is not in the group keeps its old value.
- R9: A start edge is ignored if it is seen while `busy_o` is 0, or during the 20-edge acquisition phase that follows each group. A `start_i` held high does not start a second group.
- R10: Driving `rst_n` low during a group aborts it at once: `busy_o` returns to 1 and all result registers clear to 0.
- R11: Each 12-bit result register holds the 11-bit result in bits 11:1, with bit 0 always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; sequencing acts on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, may be asynchronous |
| mode_i | input | 2 | Group mode select |
| aux_sel_i | input | 2 | Auxiliary input select |
| conv_data_i | input | 11 | Result from the converter stub for the current slot |
| busy_o | output | 1 | Low while a group is being converted |
| conv_slot_o | output | 2 | Slot being converted (0 VIN1, 1 VIN2, 2 VIN3, 3 AUX) |
| conv_aux_o | output | 2 | Latched auxiliary select for the stub |
| res_vin1_o | output | 12 | Readable VIN1 result |
| res_vin2_o | output | 12 | Readable VIN2 result |
| res_vin3_o | output | 12 | Readable VIN3 result |
| res_aux_o | output | 12 | Readable AUX result |

## Verification
Two pairs of events can fall on the same falling edge.

The first pair is the end of a group, where BUSY rises and the bank commits, and the qualification of a fresh start edge. The bench times a start rise so that its third falling edge is the commit edge. It then requires that the results commit correctly and that BUSY stays high for the following 40 cycles.

The second pair is a reset arriving in the middle of a group's slots. The bench expects BUSY high and all registers cleared, and it expects a start edge right after the reset release to be ignored.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NUM_SLOTS = 4;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  typedef enum logic [1:0] {
    PH_ACQ  = 2'd0,
    PH_IDLE = 2'd1,
    PH_CONV = 2'd2
  } phase_e;

  // bit 0 VIN1, bit 1 VIN2, bit 2 VIN3, bit 3 AUX
  function automatic logic [NUM_SLOTS-1:0] group_mask(input logic [1:0] mode);
    logic [NUM_SLOTS-1:0] m;
    m    = 4'b0110;
    m[0] = mode[1];
    m[3] = mode[0];
    return m;
  endfunction
endpackage

// File: rtl/adc_start_sync.sv
module adc_start_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], req_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/adc_slot_walker.sv
module adc_slot_walker #(
  parameter int N  = 4,
  parameter int SW = $clog2(N)
) (
  input  logic [N-1:0]  mask_i,
  input  logic [SW-1:0] cur_i,
  output logic [SW-1:0] first_o,
  output logic [SW-1:0] next_o,
  output logic          last_o
);
  always_comb begin
    first_o = '0;
    next_o  = cur_i;
    last_o  = 1'b1;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        first_o = SW'(i);
        if (i > int'(cur_i)) begin
          next_o = SW'(i);
          last_o = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import adc_seq_pkg::*;
#(
  parameter int HOLD_CYCLES = 20,
  parameter int SLOT_CYCLES = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go_i,
  input  logic [1:0]           mode_i,
  input  logic [1:0]           aux_i,
  output logic                 busy_o,
  output logic [SLOT_W-1:0]    slot_o,
  output logic [1:0]           aux_o,
  output logic [NUM_SLOTS-1:0] mask_o,
  output logic                 cap_o,
  output logic                 final_o
);
  localparam int CMAX = (HOLD_CYCLES > SLOT_CYCLES) ? HOLD_CYCLES : SLOT_CYCLES;
  localparam int CW   = $clog2(CMAX);

  phase_e               phase_q;
  logic [CW-1:0]        cnt_q;
  logic [SLOT_W-1:0]    slot_q;
  logic [NUM_SLOTS-1:0] mask_q;
  logic [1:0]           aux_q;
  logic                 busy_q;

  logic [NUM_SLOTS-1:0] walk_mask;
  logic [SLOT_W-1:0]    first_slot, next_slot;
  logic                 last_slot;
  logic                 slot_end;

  assign walk_mask = (phase_q == PH_IDLE) ? group_mask(mode_i) : mask_q;

  adc_slot_walker #(.N(NUM_SLOTS), .SW(SLOT_W)) u_walk (
    .mask_i  (walk_mask),
    .cur_i   (slot_q),
    .first_o (first_slot),
    .next_o  (next_slot),
    .last_o  (last_slot)
  );

  assign slot_end = (phase_q == PH_CONV) && (cnt_q == CW'(SLOT_CYCLES - 1));

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ACQ;
      cnt_q   <= '0;
      slot_q  <= '0;
      mask_q  <= '0;
      aux_q   <= '0;
      busy_q  <= 1'b1;
    end else begin
      case (phase_q)
        PH_ACQ: begin
          if (cnt_q == CW'(HOLD_CYCLES - 1)) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_IDLE: begin
          if (go_i) begin
            phase_q <= PH_CONV;
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            mask_q  <= walk_mask;
            aux_q   <= aux_i;
            slot_q  <= first_slot;
          end
        end
        PH_CONV: begin
          if (slot_end) begin
            cnt_q <= '0;
            if (last_slot) begin
              phase_q <= PH_ACQ;
              busy_q  <= 1'b1;
            end else begin
              slot_q <= next_slot;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          phase_q <= PH_ACQ;
          cnt_q   <= '0;
          busy_q  <= 1'b1;
        end
      endcase
    end
  end

  assign busy_o  = busy_q;
  assign slot_o  = slot_q;
  assign aux_o   = aux_q;
  assign mask_o  = mask_q;
  assign cap_o   = slot_end;
  assign final_o = slot_end & last_slot;
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 11
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cap_i,
  input  logic [SLOT_W-1:0]                slot_i,
  input  logic [RES_W-1:0]                 data_i,
  input  logic                             commit_i,
  input  logic [NUM_SLOTS-1:0]             mask_i,
  output logic [NUM_SLOTS-1:0][RES_W:0]    read_o
);
  for (genvar c = 0; c < NUM_SLOTS; c++) begin : g_ch
    logic [RES_W-1:0] shadow_q;
    logic [RES_W:0]   read_q;
    logic             hit;

    assign hit = cap_i && (slot_i == SLOT_W'(c));

    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q <= '0;
        read_q   <= '0;
      end else begin
        if (hit) shadow_q <= data_i;
        if (commit_i && mask_i[c])
          read_q <= {(hit ? data_i : shadow_q), 1'b0};
      end
    end

    assign read_o[c] = read_q;
  end
endmodule

// File: rtl/adc_group_sequencer.sv
module adc_group_sequencer
  import adc_seq_pkg::*;
#(
  parameter int HOLD_CYCLES = 20,
  parameter int SLOT_CYCLES = 40,
  parameter int RES_W       = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       aux_sel_i,
  input  logic [RES_W-1:0] conv_data_i,
  output logic             busy_o,
  output logic [1:0]       conv_slot_o,
  output logic [1:0]       conv_aux_o,
  output logic [RES_W:0]   res_vin1_o,
  output logic [RES_W:0]   res_vin2_o,
  output logic [RES_W:0]   res_vin3_o,
  output logic [RES_W:0]   res_aux_o
);
  logic                          go;
  logic [SLOT_W-1:0]             slot;
  logic [NUM_SLOTS-1:0]          mask;
  logic                          cap, fin;
  logic [NUM_SLOTS-1:0][RES_W:0] bank;

  adc_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (start_i),
    .rise_o (go)
  );

  adc_seq_core #(.HOLD_CYCLES(HOLD_CYCLES), .SLOT_CYCLES(SLOT_CYCLES)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .go_i    (go),
    .mode_i  (mode_i),
    .aux_i   (aux_sel_i),
    .busy_o  (busy_o),
    .slot_o  (slot),
    .aux_o   (conv_aux_o),
    .mask_o  (mask),
    .cap_o   (cap),
    .final_o (fin)
  );

  adc_result_bank #(.RES_W(RES_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_i    (cap),
    .slot_i   (slot),
    .data_i   (conv_data_i),
    .commit_i (fin),
    .mask_i   (mask),
    .read_o   (bank)
  );

  assign conv_slot_o = slot;
  assign res_vin1_o  = bank[0];
  assign res_vin2_o  = bank[1];
  assign res_vin3_o  = bank[2];
  assign res_aux_o   = bank[3];
endmodule

// File: rtl/adc_group_sequencer_chk.sv
module adc_group_sequencer_chk #(
  parameter int HOLD  = 20,
  parameter int SLOT  = 40,
  parameter int RES_W = 11
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     mode_i,
  input logic           busy_o,
  input logic [1:0]     conv_slot_o,
  input logic [1:0]     conv_aux_o,
  input logic [RES_W:0] res_vin1_o,
  input logic [RES_W:0] res_vin2_o,
  input logic [RES_W:0] res_vin3_o,
  input logic [RES_W:0] res_aux_o
);
  logic [1:0] mode_seen;
  logic [3:0] grp;
  int         lo_cnt, hi_cnt;

  always_comb begin
    case (mode_seen)
      2'b00:   grp = 4'b0110;
      2'b01:   grp = 4'b1110;
      2'b10:   grp = 4'b0111;
      default: grp = 4'b1111;
    endcase
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_seen <= 2'b00;
      lo_cnt    <= 0;
      hi_cnt    <= 0;
    end else begin
      if (busy_o) mode_seen <= mode_i;
      lo_cnt <= busy_o ? 0 : lo_cnt + 1;
      hi_cnt <= busy_o ? ((hi_cnt < 100000) ? hi_cnt + 1 : hi_cnt) : 0;
    end
  end

  assert_busy_len_R7: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (lo_cnt == SLOT * $countones(grp)));

  assert_acq_gap_R9: assert property (@(negedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (hi_cnt > HOLD));

  assert_slot_in_group_R3: assert property (@(negedge clk) disable iff (!rst_n)
    !busy_o |-> grp[conv_slot_o]);

  assert_slot_order_R4: assert property (@(negedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o) && (conv_slot_o != $past(conv_slot_o)))
      |-> (conv_slot_o > $past(conv_slot_o)));

  assert_aux_held_R6: assert property (@(negedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> $stable(conv_aux_o));

  assert_vin1_hold_R8: assert property (@(negedge clk) disable iff (!rst_n)
    !$stable(res_vin1_o) |-> $rose(busy_o));
  assert_vin2_hold_R8: assert property (@(negedge clk) disable iff (!rst_n)
    !$stable(res_vin2_o) |-> $rose(busy_o));
  assert_vin3_hold_R8: assert property (@(negedge clk) disable iff (!rst_n)
    !$stable(res_vin3_o) |-> $rose(busy_o));
  assert_aux_hold_R8: assert property (@(negedge clk) disable iff (!rst_n)
    !$stable(res_aux_o) |-> $rose(busy_o));
endmodule

bind adc_group_sequencer adc_group_sequencer_chk #(
  .HOLD(HOLD_CYCLES), .SLOT(SLOT_CYCLES), .RES_W(RES_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .busy_o      (busy_o),
  .conv_slot_o (conv_slot_o),
  .conv_aux_o  (conv_aux_o),
  .res_vin1_o  (res_vin1_o),
  .res_vin2_o  (res_vin2_o),
  .res_vin3_o  (res_vin3_o),
  .res_aux_o   (res_aux_o)
);

// File: tb/adc_group_sequencer_test.sv
`timescale 1ns/1ps
module adc_group_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [1:0]  aux_sel_i = 2'b00;
  logic [10:0] conv_data_i;
  logic        busy_o;
  logic [1:0]  conv_slot_o, conv_aux_o;
  logic [11:0] res_vin1_o, res_vin2_o, res_vin3_o, res_aux_o;

  int vectors = 0;
  int miscompares = 0;
  int epoch = 0;
  logic [11:0] exp_r [4];

  always #4 clk = ~clk;

  function automatic logic [10:0] stub_val(input int ep, input logic [1:0] s, input logic [1:0] a);
    return 11'((ep * 97 + int'(s) * 13 + int'(a) * 5 + 7) % 2048);
  endfunction

  assign conv_data_i = stub_val(epoch, conv_slot_o, conv_aux_o);

  adc_group_sequencer uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .aux_sel_i(aux_sel_i), .conv_data_i(conv_data_i), .busy_o(busy_o),
    .conv_slot_o(conv_slot_o), .conv_aux_o(conv_aux_o),
    .res_vin1_o(res_vin1_o), .res_vin2_o(res_vin2_o),
    .res_vin3_o(res_vin3_o), .res_aux_o(res_aux_o)
  );

  function automatic logic [3:0] bench_mask(input logic [1:0] m);
    case (m)
      2'b00:   return 4'b0110;
      2'b01:   return 4'b1110;
      2'b10:   return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [11:0] rd(input int i);
    case (i)
      0:       return res_vin1_o;
      1:       return res_vin2_o;
      2:       return res_vin3_o;
      default: return res_aux_o;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < 4; i++)
      check(rd(i) == exp_r[i], req, 32'(rd(i)), 32'(exp_r[i]));
  endtask

  task automatic quiet(input int cycles, input string req);
    bit ok = 1'b1;
    for (int k = 0; k < cycles; k++) begin
      @(posedge clk);
      if (!busy_o) ok = 1'b0;
    end
    check(ok, req, 32'(ok), 32'd1);
  endtask

  // flavor: 0 plain, 1 start during busy, 2 start during acquisition,
  // 3 start qualified on the commit edge, 4 mode/aux change mid group
  task automatic run_group(input logic [1:0] m, input logic [1:0] a, input int flavor);
    int n, lo, nseq, k;
    logic [1:0] seq [8];
    logic [3:0] mk;
    logic [11:0] old_r [4];
    bit mid_ok, ord_ok;
    @(posedge clk);
    start_i = 1'b0;
    mode_i = m;
    aux_sel_i = a;
    repeat (3) @(posedge clk);
    epoch++;
    mk = bench_mask(m);
    n = $countones(mk);
    old_r = exp_r;
    start_i = 1'b1;
    @(posedge clk);
    @(posedge clk);
    check(busy_o == 1'b1, "R2 busy still high two edges after start", 32'(busy_o), 32'd1);
    @(posedge clk);
    check(busy_o == 1'b0, "R2 busy low three edges after start", 32'(busy_o), 32'd0);
    lo = 0;
    nseq = 0;
    mid_ok = 1'b1;
    while (busy_o == 1'b0 && lo < 400) begin
      lo++;
      if (nseq == 0 || seq[(nseq - 1) % 8] != conv_slot_o) begin
        if (nseq < 8) seq[nseq] = conv_slot_o;
        nseq++;
      end
      for (int i = 0; i < 4; i++) if (rd(i) != old_r[i]) mid_ok = 1'b0;
      if (lo == 4) start_i = 1'b0;
      if (flavor == 1 && lo == 50) start_i = 1'b1;
      if (flavor == 3 && lo == 40 * n - 2) start_i = 1'b1;
      if (flavor == 4 && lo == 10) begin
        mode_i = ~m;
        aux_sel_i = ~a;
      end
      @(posedge clk);
    end
    check(lo == 40 * n, "R7 busy low length", 32'(lo), 32'(40 * n));
    check(nseq == n, "R3 number of slots", 32'(nseq), 32'(n));
    ord_ok = 1'b1;
    k = 0;
    for (int c = 0; c < 4; c++) begin
      if (mk[c]) begin
        if (k >= nseq || k >= 8 || seq[k] != 2'(c)) ord_ok = 1'b0;
        k++;
      end
    end
    check(ord_ok, "R4 slot order", 32'(ord_ok), 32'd1);
    check(mid_ok, "R8 previous results held while busy", 32'(mid_ok), 32'd1);
    for (int c = 0; c < 4; c++)
      if (mk[c]) exp_r[c] = {stub_val(epoch, 2'(c), a), 1'b0};
    if (flavor == 4) check_regs("R6 latched mode/aux results");
    else             check_regs("R3 R5 R8 R11 committed results");
    case (flavor)
      1: begin
        quiet(40, "R9 start during busy ignored");
        start_i = 1'b0;
      end
      3: begin
        quiet(40, "R9 start on commit edge ignored");
        start_i = 1'b0;
      end
      2: begin
        start_i = 1'b1;
        quiet(30, "R9 start during acquisition ignored");
        start_i = 1'b0;
      end
      default: repeat (22) @(posedge clk);
    endcase
  endtask

  task automatic reset_abort();
    int lo;
    @(posedge clk);
    start_i = 1'b0;
    mode_i = 2'b11;
    aux_sel_i = 2'b10;
    repeat (3) @(posedge clk);
    epoch++;
    start_i = 1'b1;
    lo = 0;
    while (lo < 36) begin
      @(posedge clk);
      if (!busy_o) lo++;
      if (lo == 4) start_i = 1'b0;
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    check(busy_o == 1'b1, "R10 busy high after abort", 32'(busy_o), 32'd1);
    for (int i = 0; i < 4; i++) exp_r[i] = 12'h000;
    check_regs("R10 registers cleared by abort");
    rst_n = 1'b1;
    start_i = 1'b1;
    quiet(30, "R1 start during post-reset acquisition ignored");
    start_i = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", vectors, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) exp_r[i] = 12'h000;
    repeat (4) @(posedge clk);
    check(busy_o == 1'b1, "R1 busy high in reset", 32'(busy_o), 32'd1);
    check_regs("R1 registers zero in reset");
    rst_n = 1'b1;
    start_i = 1'b1;
    quiet(30, "R1 start right after reset ignored");
    start_i = 1'b0;
    repeat (3) @(posedge clk);

    run_group(2'b00, 2'b00, 0);
    run_group(2'b01, 2'b01, 0);
    run_group(2'b10, 2'b10, 0);
    run_group(2'b11, 2'b11, 0);
    run_group(2'b11, 2'b00, 0);
    run_group(2'b01, 2'b10, 0);
    run_group(2'b10, 2'b01, 1);
    run_group(2'b01, 2'b11, 2);
    run_group(2'b11, 2'b01, 3);
    run_group(2'b00, 2'b10, 3);
    run_group(2'b01, 2'b00, 4);
    run_group(2'b10, 2'b11, 4);
    reset_abort();
    run_group(2'b00, 2'b01, 0);
    for (int r = 0; r < 12; r++)
      run_group(2'($urandom_range(3)), 2'($urandom_range(3)), int'($urandom_range(4)));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule